// File: doc/BRIEF.md
# Temperature Sample Artifact Gate

This block conditions a stream of raw temperature converter codes before they reach a display or alarm path. Each code arrives with a one-cycle valid strobe. The block first tests the raw code against an open-sensor limit and a short-sensor limit. It then tests the jump from the most recently accepted code against a configured per-sample step limit. A code that passes all three tests goes into a first-order smoother. A code that fails any test is rejected, and the block enters a degraded state.

While degraded, the smoothed output is frozen at its last good value. A two-bit cause code and a degraded flag tell downstream logic that the reading is stale. The block returns to normal output only after a configurable run of consecutive clean codes, so the output cannot flap between states. Smoothing removes jitter, and gating catches artifacts. A fault is therefore always reported and never absorbed into the average.

All limits, the recovery run length and the smoother shift come in as register inputs. Linearization and calibration happen downstream.

Top module: `temp_artifact_gate`

## Requirements
- R1: `out_valid` is high exactly one cycle after each cycle with `in_valid` high, whether the output is updated or held. `out_value` and `out_status` do not change in a cycle that follows a cycle without `in_valid`.
- R2: A code greater than or equal to `cfg_open_lim` is rejected with status 2'b01 (open). The open test takes priority over the short and step tests.
- R3: A code less than or equal to `cfg_short_lim` that is not open is rejected with status 2'b10 (short).
- R4: Once seeded, a code whose absolute difference from the last accepted raw code exceeds `cfg_max_step` is rejected with status 2'b11 (implausible step). A difference exactly equal to the limit is accepted.
- R5: The first clean code after reset loads both the smoother state and the last-accepted register directly. No step test and no smoothing apply to it, so `out_value` equals that code.
- R6: Any rejection sets `out_degraded` and a nonzero status. While degraded, `out_value` holds its last good value.
- R7: The block leaves the degraded state on the N-th consecutive clean code, where N is `cfg_recover_n` and a value of 0 acts as 1. During recovery, clean codes are step-tested against the last accepted code but do not update it. The N-th clean code is accepted and updates the smoother, and the status returns to 2'b00.
- R8: A rejected code during recovery restarts the consecutive count from zero. The status then shows the cause of that most recent rejection.
- R9: An accepted code x updates the smoother state y to y + floor((x - y) / 2^k), where k is `cfg_shift` (0 to 7). With k = 0 the output equals the code.
- R10: After reset, `out_valid` is 0, `out_value` is 0, `out_status` is 2'b00 and `out_degraded` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Raw code strobe |
| in_code | input | CODE_W | Raw converter code, unsigned |
| cfg_open_lim | input | CODE_W | Codes at or above this value are open-sensor |
| cfg_short_lim | input | CODE_W | Codes at or below this value are short-sensor |
| cfg_max_step | input | CODE_W | Largest accepted jump from the last accepted code |
| cfg_recover_n | input | CNT_W | Clean codes in a row needed to recover (0 acts as 1) |
| cfg_shift | input | 3 | Smoother shift k |
| out_valid | output | 1 | Output strobe, one cycle after `in_valid` |
| out_value | output | CODE_W | Smoothed or held value |
| out_status | output | 2 | 00 normal, 01 open, 10 short, 11 implausible step |
| out_degraded | output | 1 | Output is held because of a fault |

## Verification
The assertions assume two things about the inputs. First, `cfg_short_lim` is below `cfg_open_lim`. Second, the configuration inputs are steady for as long as codes are streaming, so that holds and recoveries can be traced to code content alone. The stimulus follows both assumptions: it changes the configuration only during reset or idle gaps, and it sends each code as a single-cycle strobe separated by idle cycles. The hold and the no-change-without-strobe properties rely on these gaps to show that the output stays frozen between strobes.

// File: rtl/tag_pkg.sv
package tag_pkg;
    typedef enum logic [1:0] {
        ST_OK    = 2'b00,
        ST_OPEN  = 2'b01,
        ST_SHORT = 2'b10,
        ST_STEP  = 2'b11
    } gate_status_e;
endpackage

// File: rtl/tag_classify.sv
module tag_classify
    import tag_pkg::*;
#(
    parameter int CODE_W = 16
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] last_good,
    input  logic              seeded,
    input  logic [CODE_W-1:0] open_lim,
    input  logic [CODE_W-1:0] short_lim,
    input  logic [CODE_W-1:0] max_step,
    output gate_status_e      verdict
);
    localparam int DW = CODE_W + 1;

    logic signed [DW-1:0] diff;
    logic        [DW-1:0] mag;

    always_comb begin
        diff = $signed({1'b0, code}) - $signed({1'b0, last_good});
        mag  = diff[DW-1] ? DW'(-diff) : DW'(diff);
        if (code >= open_lim)
            verdict = ST_OPEN;
        else if (code <= short_lim)
            verdict = ST_SHORT;
        else if (seeded && (mag > {1'b0, max_step}))
            verdict = ST_STEP;
        else
            verdict = ST_OK;
    end
endmodule

// File: rtl/tag_iir.sv
module tag_iir #(
    parameter int CODE_W = 16
) (
    input  logic [CODE_W-1:0] y_now,
    input  logic [CODE_W-1:0] x_in,
    input  logic [2:0]        shift,
    output logic [CODE_W-1:0] y_next
);
    localparam int DW = CODE_W + 1;

    logic signed [DW-1:0] delta;
    logic signed [DW-1:0] scaled;
    logic signed [DW-1:0] total;

    always_comb begin
        delta  = $signed({1'b0, x_in}) - $signed({1'b0, y_now});
        scaled = delta >>> shift;
        total  = $signed({1'b0, y_now}) + scaled;
        y_next = total[CODE_W-1:0];
    end
endmodule

// File: rtl/temp_artifact_gate.sv
module temp_artifact_gate
    import tag_pkg::*;
#(
    parameter int CODE_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] in_code,
    input  logic [CODE_W-1:0] cfg_open_lim,
    input  logic [CODE_W-1:0] cfg_short_lim,
    input  logic [CODE_W-1:0] cfg_max_step,
    input  logic [CNT_W-1:0]  cfg_recover_n,
    input  logic [2:0]        cfg_shift,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_value,
    output logic [1:0]        out_status,
    output logic              out_degraded
);
    localparam int CW = CNT_W + 1;

    typedef struct packed {
        logic              seeded;
        logic              degraded;
        gate_status_e      status;
        logic [CNT_W-1:0]  run;
        logic [CODE_W-1:0] last_good;
        logic [CODE_W-1:0] filt;
        logic              ovalid;
    } gate_state_t;

    gate_state_t  st_q, st_d;
    gate_status_e verdict;
    logic [CODE_W-1:0] filt_step;
    logic [CW-1:0]     run_inc;
    logic [CW-1:0]     run_goal;

    tag_classify #(.CODE_W(CODE_W)) u_cls (
        .code      (in_code),
        .last_good (st_q.last_good),
        .seeded    (st_q.seeded),
        .open_lim  (cfg_open_lim),
        .short_lim (cfg_short_lim),
        .max_step  (cfg_max_step),
        .verdict   (verdict)
    );

    tag_iir #(.CODE_W(CODE_W)) u_iir (
        .y_now  (st_q.filt),
        .x_in   (in_code),
        .shift  (cfg_shift),
        .y_next (filt_step)
    );

    always_comb begin
        st_d        = st_q;
        st_d.ovalid = in_valid;
        run_inc     = {1'b0, st_q.run} + CW'(1);
        run_goal    = (cfg_recover_n == '0) ? CW'(1) : {1'b0, cfg_recover_n};
        if (in_valid) begin
            if (verdict != ST_OK) begin
                st_d.degraded = 1'b1;
                st_d.status   = verdict;
                st_d.run      = '0;
            end else if (st_q.degraded && (run_inc < run_goal)) begin
                st_d.run = run_inc[CNT_W-1:0];
            end else begin
                st_d.degraded  = 1'b0;
                st_d.status    = ST_OK;
                st_d.run       = '0;
                st_d.seeded    = 1'b1;
                st_d.last_good = in_code;
                st_d.filt      = st_q.seeded ? filt_step : in_code;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{seeded: 1'b0, degraded: 1'b0, status: ST_OK, run: '0,
                      last_good: '0, filt: '0, ovalid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid    = st_q.ovalid;
    assign out_value    = st_q.filt;
    assign out_status   = st_q.status;
    assign out_degraded = st_q.degraded;

    p_strobe_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_quiet_no_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_value) && $stable(out_status)));
    p_hold_degraded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_degraded |-> $stable(out_value));
    p_flag_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_degraded |-> (out_status != 2'b00));
    p_enter_on_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_degraded) |-> $past(in_valid));
    p_leave_on_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_degraded) |-> ($past(in_valid) && out_status == 2'b00));
endmodule

// File: tb/sim_temp_artifact_gate.sv
module sim_temp_artifact_gate;
    localparam int CLK_PERIOD = 10;
    localparam int CODE_W = 16;
    localparam int CNT_W  = 8;
    localparam int NV     = 14;

    // each vector: {code, expected value, expected status, expected degraded}
    localparam logic [34:0] VEC [NV] = '{
        {16'd1000,  16'd1000, 2'd0, 1'b0},   // R5 seed
        {16'd1100,  16'd1025, 2'd0, 1'b0},   // R9 shift 2
        {16'd1400,  16'd1025, 2'd3, 1'b1},   // R4 step 300
        {16'd1150,  16'd1025, 2'd3, 1'b1},   // R7 run 1
        {16'hF100,  16'd1025, 2'd1, 1'b1},   // R2/R8 restart
        {16'd1120,  16'd1025, 2'd1, 1'b1},   // R7
        {16'd1130,  16'd1025, 2'd1, 1'b1},   // R7
        {16'h0050,  16'd1025, 2'd2, 1'b1},   // R3/R8 restart
        {16'd1140,  16'd1025, 2'd2, 1'b1},   // R7
        {16'd1160,  16'd1025, 2'd2, 1'b1},   // R7
        {16'd1180,  16'd1063, 2'd0, 1'b0},   // R7 recover, R9
        {16'd1000,  16'd1047, 2'd0, 1'b0},   // R9 negative floor
        {16'd1200,  16'd1085, 2'd0, 1'b0},   // R4 step == limit
        {16'd1401,  16'd1085, 2'd3, 1'b1}    // R4 step limit+1
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [CODE_W-1:0] in_code = '0;
    logic [CODE_W-1:0] cfg_open_lim = 16'hF000;
    logic [CODE_W-1:0] cfg_short_lim = 16'h0100;
    logic [CODE_W-1:0] cfg_max_step = 16'd200;
    logic [CNT_W-1:0]  cfg_recover_n = 8'd3;
    logic [2:0]        cfg_shift = 3'd2;
    logic              out_valid;
    logic [CODE_W-1:0] out_value;
    logic [1:0]        out_status;
    logic              out_degraded;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    temp_artifact_gate #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
        .cfg_open_lim(cfg_open_lim), .cfg_short_lim(cfg_short_lim),
        .cfg_max_step(cfg_max_step), .cfg_recover_n(cfg_recover_n),
        .cfg_shift(cfg_shift), .out_valid(out_valid), .out_value(out_value),
        .out_status(out_status), .out_degraded(out_degraded)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one strobe; returns at the negedge where outputs reflect it
    task automatic send(input logic [CODE_W-1:0] c);
        @(negedge clk);
        in_valid = 1'b1;
        in_code = c;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_out(input string tag, input int v, input int s, input int d);
        check({tag, " value"}, out_value, v);
        check({tag, " status"}, out_status, s);
        check({tag, " degraded"}, out_degraded, d);
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        check("R10 valid", out_valid, 0);
        expect_out("R10 reset", 0, 0, 0);

        for (int i = 0; i < NV; i++) begin
            send(VEC[i][34:19]);
            check($sformatf("R1 vec%0d strobe", i), out_valid, 1);
            expect_out($sformatf("vec%0d R2 R3 R4 R6 R7 R8 R9", i),
                       VEC[i][18:3], VEC[i][2:1], VEC[i][0]);
            @(negedge clk);
            check($sformatf("R1 vec%0d idle", i), out_valid, 0);
        end

        // R5: first clean code ignores step limit and smoothing
        do_reset();
        send(16'd9000);
        expect_out("R5 seed far", 9000, 0, 0);

        // R2 boundary, N=0 acts as 1, shift 0 passthrough
        @(negedge clk);
        cfg_shift = 3'd0;
        cfg_recover_n = 8'd0;
        do_reset();
        send(16'hF000);
        expect_out("R2 open at limit", 0, 1, 1);
        send(16'd5000);
        expect_out("R7 N0 recover seeds", 5000, 0, 0);
        send(16'd5100);
        expect_out("R9 shift0 passthrough", 5100, 0, 0);
        send(16'h0100);
        expect_out("R3 short at limit", 5100, 2, 1);
        repeat (3) @(negedge clk);
        check("R1 held no strobe", out_value, 5100);
        send(16'd5150);
        expect_out("R7 N0 single clean", 5150, 0, 0);
        send(16'hFFFF);
        expect_out("R2 open beats short", 5150, 1, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule